// File: doc/BRIEF.md
# Masked-Access GPIO Pin Bank

This block is a byte-wide, memory-mapped general-purpose I/O port with three banks of eight pins, 24 pins in all. Each bank keeps an output data register, a direction register and a peripheral-hand-over register. It drives per-pin output value, output-enable and alternate-function lines, and it samples per-pin inputs through a two-flop synchronizer.

Accesses to the data and direction registers carry a pin mask in the address itself. Address bits [9:2] form an 8-bit bit-enable, so software can set, clear or sample one pin or any group of pins in a bank with a single bus access. It never needs a read-modify-write, and two agents that own different pins of one bank cannot corrupt each other's bits. Bits outside the mask keep their value on a write and read back as zero.

The bus is a simple single-cycle port. A write is taken on the clock edge where `bus_wr` is high. Read data is a combinational function of the address and the current register and synchronizer state.

Top module: `pin_bank_port`

## Requirements
- R1: After a clock edge with `rst_n` low, every pin is an input (`pin_oe` all 0), every output data bit is 0 and every alternate-function select is 0.
- R2: Address bits [13:12] select the bank, so bank n sits at byte address n × 0x1000 for n = 0, 1, 2. Accesses with bank index 3 change nothing and read as 0.
- R3: A write to a bank offset with bits [11:10] = 00 and bits [1:0] = 00 updates that bank's output data only in the bit positions set in address bits [9:2]. Bit k of the mask is address bit k+2. All other data bits keep their value, and the data bits drive `pin_out`.
- R4: A write to a bank offset with bits [11:10] = 10 and bits [1:0] = 00 updates the direction bits under the same address mask. A direction bit of 1 makes the pin an output (`pin_oe` = 1) and 0 makes it an input.
- R5: A read of the data or direction region returns 0 in every bit position that is clear in the address mask.
- R6: A data read returns the driven output value for pins whose direction bit is 1 and the synchronized pin input for pins whose direction bit is 0.
- R7: A change on `pin_in` is not visible in a data read after one clock edge. It becomes visible after the second edge.
- R8: Bank offset 0x420 holds an 8-bit alternate-function select register. It is written in full with no mask, reads back in full and drives `pin_alt`, where a 1 hands the pin to a peripheral.
- R9: Any other bank offset is reserved. This covers offsets 0x400 to 0x7FF other than 0x420, offsets 0xC00 to 0xFFF, and offsets with bits [1:0] nonzero. Writes to a reserved offset change no register, and reads from it return 0.
- R10: The output data bit of an input pin is still written and kept. It appears on `pin_out` at once and in data reads as soon as the pin is turned into an output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 14 | Byte address: bank in [13:12], offset in [11:0] |
| bus_wr | input | 1 | Write strobe, taken at the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pin_in | input | 24 | Asynchronous pin inputs, bank n in bits [8n+7:8n] |
| pin_out | output | 24 | Output data register contents |
| pin_oe | output | 24 | Output enables (direction bits) |
| pin_alt | output | 24 | Alternate-function selects |

## Verification
The registers drive the pins directly, so a wrong bit in a data, direction or select register appears on `pin_out`, `pin_oe` or `pin_alt` on the very edge of the faulty write. A mask decoded from the wrong address bits, or a write sent to the wrong bank, shows at once as a changed bit in an untouched position. The read path only reaches the pins through `bus_rdata`. A bad read mux or mask shows in the same cycle as the read, and a synchronizer with the wrong depth shows as an input change that appears one edge early or late.

// File: rtl/pinport_pkg.sv
// Package: shared constants and types for the masked-access pin port.
// Assumes banks are spaced 4 KiB apart and that a bank is at most 8 pins
// wide, so that the mask field [9:2] stays clear of the region bits [11:10].
package pinport_pkg;

    // Width of the per-bank offset field; bank index sits above it.
    localparam int OFFSET_W  = 12;
    // Lowest address bit of the pin mask field.
    localparam int MASK_LSB  = 2;
    // Offset of the alternate-function select register inside a bank.
    localparam logic [OFFSET_W-1:0] OFF_ALT = 12'h420;
    // Region codes carried in offset bits [11:10].
    localparam logic [1:0] RGN_DATA = 2'b00;
    localparam logic [1:0] RGN_DIR  = 2'b10;

    // Register class picked by one bus address.
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_DATA = 2'd1,
        ACC_DIR  = 2'd2,
        ACC_ALT  = 2'd3
    } access_e;

endpackage

// File: rtl/pinport_sync.sv
// Module: multi-stage synchronizer for the asynchronous pin inputs.
// Assumes each pin is an independent slow signal; no bus coherence is
// needed across pins. STAGES must be at least 2.
module pinport_sync #(
    parameter int WIDTH  = 24,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage: capture the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_in;
    end

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_stage
            // Later stages: shift the sample one flop further.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end

            // R7: each stage takes exactly the previous stage's value.
            assert_stage_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> stage_q[s] == $past(stage_q[s-1]));
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/pinport_decode.sv
// Module: bus address decoder. It splits the address into bank index,
// register class and pin mask, and raises one write enable per bank and
// register class. Assumes a single-cycle bus with no wait states.
module pinport_decode
    import pinport_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int NUM_BANKS = 3,
    parameter int BANK_W    = 8,
    localparam int SEL_W    = ADDR_W - OFFSET_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr,
    output access_e              access,
    output logic [SEL_W-1:0]     bank_idx,
    output logic                 bank_hit,
    output logic [BANK_W-1:0]    mask,
    output logic [NUM_BANKS-1:0] we_data,
    output logic [NUM_BANKS-1:0] we_dir,
    output logic [NUM_BANKS-1:0] we_alt
);

    logic [OFFSET_W-1:0] offset;

    assign offset   = addr[OFFSET_W-1:0];
    assign bank_idx = addr[ADDR_W-1:OFFSET_W];
    assign mask     = addr[MASK_LSB+BANK_W-1:MASK_LSB];

    // Bank index check: indices at or above NUM_BANKS are unmapped.
    always_comb begin
        bank_hit = (32'(bank_idx) < NUM_BANKS);
    end

    // Register class: masked data, masked direction, full alt select, or none.
    always_comb begin
        access = ACC_NONE;
        if (offset[1:0] == 2'b00) begin
            if (offset[11:10] == RGN_DATA)     access = ACC_DATA;
            else if (offset[11:10] == RGN_DIR) access = ACC_DIR;
            else if (offset == OFF_ALT)        access = ACC_ALT;
        end
    end

    genvar b;
    generate
        for (b = 0; b < NUM_BANKS; b++) begin : g_we
            logic this_bank;
            assign this_bank  = wr && bank_hit && (bank_idx == SEL_W'(b));
            assign we_data[b] = this_bank && (access == ACC_DATA);
            assign we_dir[b]  = this_bank && (access == ACC_DIR);
            assign we_alt[b]  = this_bank && (access == ACC_ALT);
        end
    endgenerate

    // R2: one bus write reaches at most one register of one bank.
    assert_one_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({we_data, we_dir, we_alt}));

    // R9: no write enable without a write strobe.
    assert_no_spurious_we_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |-> ({we_data, we_dir, we_alt} == '0));

endmodule

// File: rtl/pinport_bank.sv
// Module: one bank of pins. It holds the output data, direction and
// alternate-select registers, applies masked updates and forms the
// per-pin read value. Assumes the write enables are mutually exclusive.
module pinport_bank #(
    parameter int BANK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_data,
    input  logic              we_dir,
    input  logic              we_alt,
    input  logic [BANK_W-1:0] mask,
    input  logic [BANK_W-1:0] wdata,
    input  logic [BANK_W-1:0] pin_sync,
    output logic [BANK_W-1:0] data_q,
    output logic [BANK_W-1:0] dir_q,
    output logic [BANK_W-1:0] alt_q,
    output logic [BANK_W-1:0] pin_val
);

    // Output data: merge write data into the masked bit positions only.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (we_data) data_q <= (data_q & ~mask) | (wdata & mask);
    end

    // Direction: same masked merge; 1 means the pin drives.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '0;
        else if (we_dir) dir_q <= (dir_q & ~mask) | (wdata & mask);
    end

    // Alternate-function select: whole-byte write, mask not applied.
    always_ff @(posedge clk) begin
        if (!rst_n)      alt_q <= '0;
        else if (we_alt) alt_q <= wdata;
    end

    // Pin value for reads: driven value on outputs, sampled input otherwise.
    always_comb begin
        pin_val = (dir_q & data_q) | (~dir_q & pin_sync);
    end

    // R1: reset clears every register of the bank.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (data_q == '0 && dir_q == '0 && alt_q == '0));

    // R3: a data write leaves unmasked bits untouched.
    assert_data_unmasked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        we_data |=> ((data_q ^ $past(data_q)) & ~$past(mask)) == '0);

    // R3: with no data write the data register holds.
    assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !we_data |=> $stable(data_q));

    // R4: a direction write leaves unmasked bits untouched.
    assert_dir_unmasked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        we_dir |=> ((dir_q ^ $past(dir_q)) & ~$past(mask)) == '0);

    // R4: with no direction write the direction register holds.
    assert_dir_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !we_dir |=> $stable(dir_q));

    // R8: the select register only changes on its own write.
    assert_alt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !we_alt |=> $stable(alt_q));

endmodule

// File: rtl/pin_bank_port.sv
// Module: top of the masked-access GPIO port. It ties the decoder, the
// input synchronizer and one bank instance per group of pins together and
// muxes the read data. Assumes a single-cycle bus with combinational reads.
module pin_bank_port
    import pinport_pkg::*;
#(
    parameter int NUM_BANKS   = 3,
    parameter int BANK_W      = 8,
    parameter int ADDR_W      = 14,
    parameter int SYNC_STAGES = 2,
    localparam int PINS       = NUM_BANKS * BANK_W,
    localparam int SEL_W      = ADDR_W - OFFSET_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BANK_W-1:0] bus_wdata,
    output logic [BANK_W-1:0] bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic [PINS-1:0]   pin_alt
);

    access_e              access;
    logic [SEL_W-1:0]     bank_idx;
    logic                 bank_hit;
    logic [BANK_W-1:0]    mask;
    logic [NUM_BANKS-1:0] we_data;
    logic [NUM_BANKS-1:0] we_dir;
    logic [NUM_BANKS-1:0] we_alt;
    logic [PINS-1:0]      pin_sync;

    logic [BANK_W-1:0] bank_val [NUM_BANKS];
    logic [BANK_W-1:0] bank_dir [NUM_BANKS];
    logic [BANK_W-1:0] bank_alt [NUM_BANKS];

    pinport_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W)
    ) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wr       (bus_wr),
        .access   (access),
        .bank_idx (bank_idx),
        .bank_hit (bank_hit),
        .mask     (mask),
        .we_data  (we_data),
        .we_dir   (we_dir),
        .we_alt   (we_alt)
    );

    pinport_sync #(
        .WIDTH  (PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    genvar b;
    generate
        for (b = 0; b < NUM_BANKS; b++) begin : g_bank
            pinport_bank #(
                .BANK_W (BANK_W)
            ) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .we_data  (we_data[b]),
                .we_dir   (we_dir[b]),
                .we_alt   (we_alt[b]),
                .mask     (mask),
                .wdata    (bus_wdata),
                .pin_sync (pin_sync[b*BANK_W +: BANK_W]),
                .data_q   (pin_out[b*BANK_W +: BANK_W]),
                .dir_q    (pin_oe[b*BANK_W +: BANK_W]),
                .alt_q    (pin_alt[b*BANK_W +: BANK_W]),
                .pin_val  (bank_val[b])
            );
            assign bank_dir[b] = pin_oe[b*BANK_W +: BANK_W];
            assign bank_alt[b] = pin_alt[b*BANK_W +: BANK_W];
        end
    endgenerate

    // Read mux: pick the addressed bank, then the register class and mask.
    always_comb begin
        logic [BANK_W-1:0] sel_val;
        logic [BANK_W-1:0] sel_dir;
        logic [BANK_W-1:0] sel_alt;
        sel_val = '0;
        sel_dir = '0;
        sel_alt = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (bank_idx == SEL_W'(i)) begin
                sel_val = bank_val[i];
                sel_dir = bank_dir[i];
                sel_alt = bank_alt[i];
            end
        end
        bus_rdata = '0;
        if (bank_hit) begin
            case (access)
                ACC_DATA: bus_rdata = sel_val & mask;
                ACC_DIR:  bus_rdata = sel_dir & mask;
                ACC_ALT:  bus_rdata = sel_alt;
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R5: masked reads never return bits outside the address mask.
    assert_read_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[OFFSET_W-1:OFFSET_W-2] == RGN_DATA || bus_addr[OFFSET_W-1:OFFSET_W-2] == RGN_DIR)
        |-> (bus_rdata & ~bus_addr[MASK_LSB+BANK_W-1:MASK_LSB]) == '0);

    // R2: an unmapped bank index reads as zero.
    assert_unmapped_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(bus_addr[ADDR_W-1:OFFSET_W]) >= NUM_BANKS) |-> bus_rdata == '0);

    // R9: reserved offsets read as zero.
    assert_reserved_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[1:0] != 2'b00) |-> bus_rdata == '0);

endmodule

// File: tb/test_pin_bank_port.sv
// Directed bench: one task per scenario, each checking its own results
// against a bench-side model built from the requirements.
module test_pin_bank_port;

    localparam int CLK_PERIOD = 10;
    localparam int PINS = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [PINS-1:0] pin_in = '0;
    logic [PINS-1:0] pin_out;
    logic [PINS-1:0] pin_oe;
    logic [PINS-1:0] pin_alt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model of the registers.
    logic [PINS-1:0] m_out = '0;
    logic [PINS-1:0] m_dir = '0;
    logic [PINS-1:0] m_alt = '0;

    pin_bank_port i_pin_bank_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .pin_alt   (pin_alt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [13:0] a_data(int bank, logic [7:0] m);
        return 14'((bank << 12) | (int'(m) << 2));
    endfunction
    function automatic logic [13:0] a_dir(int bank, logic [7:0] m);
        return 14'((bank << 12) | 'h800 | (int'(m) << 2));
    endfunction
    function automatic logic [13:0] a_alt(int bank);
        return 14'((bank << 12) | 'h420);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [13:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [13:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        #1 d = bus_rdata;
    endtask

    // Masked model updates taken from R3, R4.
    task automatic wr_data(int bank, logic [7:0] m, logic [7:0] d);
        bus_write(a_data(bank, m), d);
        for (int i = 0; i < 8; i++) if (m[i]) m_out[bank*8+i] = d[i];
    endtask
    task automatic wr_dir(int bank, logic [7:0] m, logic [7:0] d);
        bus_write(a_dir(bank, m), d);
        for (int i = 0; i < 8; i++) if (m[i]) m_dir[bank*8+i] = d[i];
    endtask

    task automatic check_pins(string tag);
        chk({tag, " pin_out"}, 32'(pin_out), 32'(m_out));
        chk({tag, " pin_oe"},  32'(pin_oe),  32'(m_dir));
        chk({tag, " pin_alt"}, 32'(pin_alt), 32'(m_alt));
    endtask

    task automatic t_reset;
        logic [7:0] r;
        #1;
        check_pins("R1 reset");
        bus_read(a_data(0, 8'hFF), r);
        chk("R1 reset data read", 32'(r), 32'h0);
    endtask

    task automatic t_data_masked;
        wr_data(0, 8'hFF, 8'hA5);
        chk("R3 full write", 32'(pin_out[7:0]), 32'hA5);
        wr_data(0, 8'h04, 8'h00);   // clear pin 2 only
        chk("R3 clear one pin", 32'(pin_out[7:0]), 32'hA1);
        wr_data(0, 8'h10, 8'hFF);   // set pin 4 only
        chk("R3 set one pin", 32'(pin_out[7:0]), 32'hB1);
        check_pins("R3 others unchanged");
    endtask

    task automatic t_dir_masked;
        wr_dir(1, 8'h0F, 8'hFF);
        chk("R4 set low nibble", 32'(pin_oe[15:8]), 32'h0F);
        wr_dir(1, 8'h81, 8'h00);
        chk("R4 clear pins 0 and 7", 32'(pin_oe[15:8]), 32'h0E);
        check_pins("R4 others unchanged");
    endtask

    task automatic t_bank_decode;
        logic [7:0] r;
        wr_data(2, 8'hFF, 8'h3C);
        chk("R2 bank 2 at 0x2000", 32'(pin_out[23:16]), 32'h3C);
        check_pins("R2 banks 0 1 untouched");
        bus_write(14'h3000 | 14'(8'hFF << 2), 8'hFF);
        check_pins("R2 unmapped bank write");
        bus_read(14'h3000 | 14'(8'hFF << 2), r);
        chk("R2 unmapped bank read", 32'(r), 32'h0);
    endtask

    task automatic t_read_paths;
        logic [7:0] r;
        logic [7:0] exp;
        @(negedge clk);
        pin_in = 24'hC3_5A_96;
        repeat (3) @(negedge clk);
        wr_data(1, 8'hFF, 8'hF0);
        exp = (m_dir[15:8] & m_out[15:8]) | (~m_dir[15:8] & pin_in[15:8]);
        bus_read(a_data(1, 8'hFF), r);
        chk("R6 mixed in/out read", 32'(r), 32'(exp));
        bus_read(a_data(1, 8'h03), r);
        chk("R5 data read masked", 32'(r), 32'(exp & 8'h03));
        bus_read(a_dir(1, 8'h0C), r);
        chk("R5 dir read masked", 32'(r), 32'(m_dir[15:8] & 8'h0C));
        bus_read(a_data(0, 8'hFF), r);
        chk("R6 input bank read", 32'(r), 32'h96);
    endtask

    task automatic t_sync;
        logic [7:0] r;
        @(negedge clk);
        bus_addr = a_data(0, 8'hFF);
        pin_in[7:0] = 8'h69;
        #1 r = bus_rdata;
        chk("R7 before any edge", 32'(r), 32'h96);
        @(negedge clk);
        #1 r = bus_rdata;
        chk("R7 after one edge", 32'(r), 32'h96);
        @(negedge clk);
        #1 r = bus_rdata;
        chk("R7 after two edges", 32'(r), 32'h69);
    endtask

    task automatic t_alt;
        logic [7:0] r;
        bus_write(a_alt(2), 8'h96);
        m_alt[23:16] = 8'h96;
        check_pins("R8 alt write");
        bus_read(a_alt(2), r);
        chk("R8 alt read back", 32'(r), 32'h96);
        bus_write(a_alt(0), 8'h01);
        m_alt[7:0] = 8'h01;
        check_pins("R8 alt bank 0");
    endtask

    task automatic t_reserved;
        logic [7:0] r;
        bus_write(14'h0400, 8'hFF);
        bus_write(14'h0C00 | 14'(8'hFF << 2), 8'hFF);
        bus_write(a_dir(0, 8'hFF) | 14'h1, 8'hFF);
        bus_write(a_data(1, 8'hFF) | 14'h2, 8'h00);
        check_pins("R9 reserved writes");
        bus_read(14'h0400, r);
        chk("R9 reserved read 0x400", 32'(r), 32'h0);
        bus_read(a_alt(2) | 14'h1, r);
        chk("R9 misaligned read", 32'(r), 32'h0);
    endtask

    task automatic t_hold_input;
        logic [7:0] r;
        wr_data(2, 8'h01, 8'h00);            // pin 16 data 0, pin is input
        @(negedge clk);
        pin_in[16] = 1'b1;
        repeat (3) @(negedge clk);
        wr_data(2, 8'h01, 8'h00);
        chk("R10 data kept while input", 32'(pin_out[16]), 32'h0);
        bus_read(a_data(2, 8'h01), r);
        chk("R10 input pin reads pad", 32'(r), 32'h01);
        wr_dir(2, 8'h01, 8'hFF);
        bus_read(a_data(2, 8'h01), r);
        chk("R10 output pin reads data", 32'(r), 32'h00);
        check_pins("R10 final state");
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_data_masked();
        t_dir_masked();
        t_bank_decode();
        t_read_paths();
        t_sync();
        t_alt();
        t_reserved();
        t_hold_input();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule